// File: doc/BRIEF.md
# Dual-Port Decoder Configuration Register Bank

This block keeps the five configuration registers that steer a broadcast data decoder: the allowed error counts, the block and frame synchronization protection counts, the initial threshold for variable-threshold error correction, and the readout block number. A host can write these registers through either of two ports. One is a three-wire clocked serial bus. The other is a parallel port with a 3-bit register select, an 8-bit data bus and a store strobe. A mode pin chooses which port is live. The stored fields are decoded into the values the synchronization, correction and readout logic use.

All host pins are brought into the main clock domain through synchronizer chains before any decoding. A serial transfer starts with an 8-bit address byte shifted while chip-enable is low. It continues with a 16-bit word shifted while chip-enable is high, and it is committed when chip-enable falls. A parallel transfer is captured on the rising edge of the store strobe. Writes are accepted from one main clock cycle after reset is released.

Top module: `cfg_regbank`

## Requirements
- R1: After reset the outputs read: back errors 2, forward errors 2, block back count 2, block forward count 8, frame back count 2, frame forward count 8, threshold 15, readout block 0.
- R2: A serial write works as follows. While chip-enable is low, eight address bits are shifted on rising serial clock edges, LSB first; the write code is 0xFA. Chip-enable then rises and 16 word bits are shifted, LSB first. When chip-enable falls, word bits 11..8 give the register address and bits 7..0 give the data.
- R3: Serial word bits 15..12 are ignored, so any value there still writes the register named by bits 11..8.
- R4: A serial transfer whose address byte is not 0xFA, including the read code 0xFB, changes no register.
- R5: A serial transfer whose data phase holds any count other than exactly 16 bits (for example 15 or 17) changes no register.
- R6: A parallel write takes the 3-bit select as the register address and the 8-bit data bus as the data, both captured at the rising edge of the store strobe.
- R7: With the mode pin high only the serial port writes. With it low only the parallel port writes. Transfers on the inactive port change nothing.
- R8: Register 0 data bits 7..4 give the back allowed error count and bits 3..0 give the forward allowed error count. Both are output unchanged.
- R9: In registers 1 (block) and 2 (frame), bits 7..4 hold the back protection value and bits 3..0 hold the forward value. Each output count is the stored nibble plus one. A nibble written as 0 leaves that nibble's stored value unchanged.
- R10: Register 3 bits 2..0 hold a threshold field, and the output threshold is 8 plus that field. Bits 7..3 are ignored.
- R11: Register 4 holds the readout block number. Values 0 to 189 are stored; values above 189 are discarded.
- R12: Writes to register addresses 5 and above change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset |
| ser_mode | input | 1 | 1 selects the serial port, 0 selects the parallel port |
| sck | input | 1 | Serial clock |
| sce | input | 1 | Serial chip-enable |
| sdi | input | 1 | Serial data in |
| par_stb | input | 1 | Parallel store strobe, captured on its rising edge |
| par_sel | input | 3 | Parallel register select |
| par_data | input | 8 | Parallel data bus |
| err_back | output | 4 | Back allowed error count |
| err_fwd | output | 4 | Forward allowed error count |
| blk_back | output | 5 | Block back protection count |
| blk_fwd | output | 5 | Block forward protection count |
| frm_back | output | 5 | Frame back protection count |
| frm_fwd | output | 5 | Frame forward protection count |
| thresh | output | 4 | Initial correction threshold |
| rd_block | output | 8 | Readout block number |

## Verification
A wrong bit counter or a wrong address match in the serial receiver shows up at the ports as a register that either fails to change or changes when it should not. Either way it is visible a few main clock cycles after chip-enable falls. A wrong nibble-guard or range guard leaves a protection count at 1 or a readout block above 189, and this appears on the cycle after the offending write. A mode mux that routes the wrong port lets a transfer on the idle port alter an output, which the bench sees right after that transfer.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int NIB_W  = 4;
    localparam int DATA_W = 2 * NIB_W;
    localparam int ADDR_W = 4;
    localparam int WORD_W = 16;
    localparam int THR_W  = 3;
    localparam int CNT_W  = NIB_W + 1;

    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } cfg_wr_t;

    localparam logic [NIB_W-1:0] DEF_ERR  = 4'd2;
    localparam logic [NIB_W-1:0] DEF_BACK = 4'd1;
    localparam logic [NIB_W-1:0] DEF_FWD  = 4'd7;
    localparam logic [THR_W-1:0] DEF_THR  = 3'd7;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_ser_rx.sv
module cfg_ser_rx
    import cfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] WR_CODE = 8'hFA
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sck_s,
    input  logic    sce_s,
    input  logic    sdi_s,
    output cfg_wr_t wr
);
    localparam int CNT_BITS = $clog2(WORD_W + 2);
    localparam logic [CNT_BITS-1:0] FULL = CNT_BITS'(WORD_W);
    localparam logic [CNT_BITS-1:0] OVER = CNT_BITS'(WORD_W + 1);

    typedef struct packed {
        logic                sck_prev;
        logic                sce_prev;
        logic [DATA_W-1:0]   addr_sh;
        logic [WORD_W-1:0]   word_sh;
        logic [CNT_BITS-1:0] cnt;
        logic                wr_mode;
        cfg_wr_t             wr;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        st_d.sce_prev = sce_s;
        st_d.wr.v     = 1'b0;
        if (sck_s && !st_q.sck_prev) begin
            if (!sce_s) begin
                st_d.addr_sh = {sdi_s, st_q.addr_sh[DATA_W-1:1]};
            end else begin
                st_d.word_sh = {sdi_s, st_q.word_sh[WORD_W-1:1]};
                if (st_q.cnt != OVER) st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (sce_s && !st_q.sce_prev) begin
            st_d.wr_mode = (st_q.addr_sh == WR_CODE);
            st_d.cnt     = '0;
        end
        if (!sce_s && st_q.sce_prev) begin
            if (st_q.wr_mode && st_q.cnt == FULL) begin
                st_d.wr.v = 1'b1;
                st_d.wr.a = st_q.word_sh[DATA_W +: ADDR_W];
                st_d.wr.d = st_q.word_sh[DATA_W-1:0];
            end
            st_d.wr_mode = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr = st_q.wr;
endmodule

// File: rtl/cfg_par_rx.sv
module cfg_par_rx
    import cfg_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_s,
    input  logic [SEL_W-1:0]  sel_s,
    input  logic [DATA_W-1:0] data_s,
    output cfg_wr_t           wr
);
    typedef struct packed {
        logic    stb_prev;
        cfg_wr_t wr;
    } par_st_t;

    par_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_s;
        st_d.wr.v     = 1'b0;
        if (stb_s && !st_q.stb_prev) begin
            st_d.wr.v = 1'b1;
            st_d.wr.a = ADDR_W'(sel_s);
            st_d.wr.d = data_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{stb_prev: 1'b1, wr: '0};
        else        st_q <= st_d;
    end

    assign wr = st_q.wr;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter int MAX_BLOCK = 189
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_wr_t          wr,
    output logic [NIB_W-1:0] err_back,
    output logic [NIB_W-1:0] err_fwd,
    output logic [CNT_W-1:0] blk_back,
    output logic [CNT_W-1:0] blk_fwd,
    output logic [CNT_W-1:0] frm_back,
    output logic [CNT_W-1:0] frm_fwd,
    output logic [NIB_W-1:0] thresh,
    output logic [DATA_W-1:0] rd_block
);
    localparam logic [NIB_W-1:0] THR_BASE = NIB_W'(1 << THR_W);

    typedef struct packed {
        logic [NIB_W-1:0]  eb, ef;
        logic [NIB_W-1:0]  bb, bf;
        logic [NIB_W-1:0]  fb, ff;
        logic [THR_W-1:0]  thr;
        logic [DATA_W-1:0] rd;
    } regs_t;

    localparam regs_t RST_REGS = '{eb: DEF_ERR, ef: DEF_ERR,
                                   bb: DEF_BACK, bf: DEF_FWD,
                                   fb: DEF_BACK, ff: DEF_FWD,
                                   thr: DEF_THR, rd: '0};

    regs_t r_d, r_q;
    logic [NIB_W-1:0] hi_n, lo_n;

    always_comb begin
        r_d  = r_q;
        hi_n = wr.d[DATA_W-1:NIB_W];
        lo_n = wr.d[NIB_W-1:0];
        if (wr.v) begin
            unique case (wr.a)
                4'd0: begin
                    r_d.eb = hi_n;
                    r_d.ef = lo_n;
                end
                4'd1: begin
                    if (hi_n != '0) r_d.bb = hi_n;
                    if (lo_n != '0) r_d.bf = lo_n;
                end
                4'd2: begin
                    if (hi_n != '0) r_d.fb = hi_n;
                    if (lo_n != '0) r_d.ff = lo_n;
                end
                4'd3: r_d.thr = wr.d[THR_W-1:0];
                4'd4: if (int'(wr.d) <= MAX_BLOCK) r_d.rd = wr.d;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_REGS;
        else        r_q <= r_d;
    end

    assign err_back = r_q.eb;
    assign err_fwd  = r_q.ef;
    assign blk_back = {1'b0, r_q.bb} + 1'b1;
    assign blk_fwd  = {1'b0, r_q.bf} + 1'b1;
    assign frm_back = {1'b0, r_q.fb} + 1'b1;
    assign frm_fwd  = {1'b0, r_q.ff} + 1'b1;
    assign thresh   = THR_BASE + NIB_W'(r_q.thr);
    assign rd_block = r_q.rd;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter int               SEL_W       = 3,
    parameter int               MAX_BLOCK   = 189,
    parameter logic [DATA_W-1:0] WR_CODE    = 8'hFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic              sck,
    input  logic              sce,
    input  logic              sdi,
    input  logic              par_stb,
    input  logic [SEL_W-1:0]  par_sel,
    input  logic [DATA_W-1:0] par_data,
    output logic [NIB_W-1:0]  err_back,
    output logic [NIB_W-1:0]  err_fwd,
    output logic [CNT_W-1:0]  blk_back,
    output logic [CNT_W-1:0]  blk_fwd,
    output logic [CNT_W-1:0]  frm_back,
    output logic [CNT_W-1:0]  frm_fwd,
    output logic [NIB_W-1:0]  thresh,
    output logic [DATA_W-1:0] rd_block
);
    localparam int SER_W = 3;
    localparam int PAR_W = 1 + SEL_W + DATA_W;

    logic [SER_W-1:0] ser_s;
    logic [PAR_W-1:0] par_s;
    logic             mode_s;
    logic             sce_s;
    cfg_wr_t          ser_wr, par_wr, acc_wr;
    logic             ready_d, ready_q;
    logic             acc_v, ser_v;

    cfg_sync #(.W(SER_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ser_sync (
        .clk(clk), .rst_n(rst_n), .d({sck, sce, sdi}), .q(ser_s));

    cfg_sync #(.W(PAR_W), .STAGES(SYNC_STAGES),
               .RST_VAL({1'b1, {(PAR_W-1){1'b0}}})) u_par_sync (
        .clk(clk), .rst_n(rst_n), .d({par_stb, par_sel, par_data}), .q(par_s));

    cfg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mode_sync (
        .clk(clk), .rst_n(rst_n), .d(ser_mode), .q(mode_s));

    assign sce_s = ser_s[1];

    cfg_ser_rx #(.WR_CODE(WR_CODE)) u_ser (
        .clk(clk), .rst_n(rst_n),
        .sck_s(ser_s[2]), .sce_s(sce_s), .sdi_s(ser_s[0]),
        .wr(ser_wr));

    cfg_par_rx #(.SEL_W(SEL_W)) u_par (
        .clk(clk), .rst_n(rst_n),
        .stb_s(par_s[PAR_W-1]),
        .sel_s(par_s[DATA_W +: SEL_W]),
        .data_s(par_s[DATA_W-1:0]),
        .wr(par_wr));

    always_comb begin
        ready_d = 1'b1;
        acc_wr  = mode_s ? ser_wr : par_wr;
        acc_wr.v = acc_wr.v & ready_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= ready_d;
    end

    assign acc_v = acc_wr.v;
    assign ser_v = ser_wr.v;

    cfg_regfile #(.MAX_BLOCK(MAX_BLOCK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(acc_wr),
        .err_back(err_back), .err_fwd(err_fwd),
        .blk_back(blk_back), .blk_fwd(blk_fwd),
        .frm_back(frm_back), .frm_fwd(frm_fwd),
        .thresh(thresh), .rd_block(rd_block));
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_v,
    input logic       ser_v,
    input logic       ce_lvl,
    input logic [3:0] err_back,
    input logic [3:0] err_fwd,
    input logic [4:0] blk_back,
    input logic [4:0] blk_fwd,
    input logic [4:0] frm_back,
    input logic [4:0] frm_fwd,
    input logic [3:0] thresh,
    input logic [7:0] rd_block
);
    logic [35:0] outs;
    assign outs = {err_back, err_fwd, blk_back, blk_fwd, frm_back, frm_fwd, thresh, rd_block};

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_v |=> $stable(outs));

    p_rd_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_block <= 8'd189);

    p_prot_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_back >= 5'd2) && (blk_fwd >= 5'd2) && (frm_back >= 5'd2) && (frm_fwd >= 5'd2));

    p_commit_ce_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_v |-> !ce_lvl);

    p_commit_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_v |=> !ser_v);
endmodule

bind cfg_regbank cfg_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_v(acc_v), .ser_v(ser_v), .ce_lvl(sce_s),
    .err_back(err_back), .err_fwd(err_fwd),
    .blk_back(blk_back), .blk_fwd(blk_fwd),
    .frm_back(frm_back), .frm_fwd(frm_fwd),
    .thresh(thresh), .rd_block(rd_block));

// File: tb/sim_cfg_regbank.sv
module sim_cfg_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_mode = 1'b1;
    logic       sck = 1'b0, sce = 1'b0, sdi = 1'b0;
    logic       par_stb = 1'b1;
    logic [2:0] par_sel = '0;
    logic [7:0] par_data = '0;
    logic [3:0] err_back, err_fwd, thresh;
    logic [4:0] blk_back, blk_fwd, frm_back, frm_fwd;
    logic [7:0] rd_block;

    always #2.5 clk = ~clk;

    cfg_regbank u0 (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode),
        .sck(sck), .sce(sce), .sdi(sdi),
        .par_stb(par_stb), .par_sel(par_sel), .par_data(par_data),
        .err_back(err_back), .err_fwd(err_fwd),
        .blk_back(blk_back), .blk_fwd(blk_fwd),
        .frm_back(frm_back), .frm_fwd(frm_fwd),
        .thresh(thresh), .rd_block(rd_block));

    typedef struct packed {
        logic [3:0] eb, ef;
        logic [4:0] bb, bf, fb, ff;
        logic [3:0] th;
        logic [7:0] rd;
    } snap_t;

    snap_t exp_q[$];
    string tag_q[$];
    snap_t model;
    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_now(input string tag);
        tick(12);
        exp_q.push_back(model);
        tag_q.push_back(tag);
        tick(2);
    endtask

    task automatic ser_bit(input logic b);
        sdi = b;
        tick(4);
        sck = 1'b1;
        tick(4);
        sck = 1'b0;
    endtask

    task automatic ser_xfer(input logic [7:0] code, input logic [16:0] word, input int nbits);
        sce = 1'b0;
        tick(4);
        for (int i = 0; i < 8; i++) ser_bit(code[i]);
        tick(4);
        sce = 1'b1;
        tick(4);
        for (int i = 0; i < nbits; i++) ser_bit(word[i]);
        tick(4);
        sce = 1'b0;
    endtask

    task automatic par_xfer(input logic [2:0] sel, input logic [7:0] d);
        par_sel  = sel;
        par_data = d;
        par_stb  = 1'b0;
        tick(6);
        par_stb  = 1'b1;
        tick(6);
    endtask

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            snap_t e;
            snap_t a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{eb: err_back, ef: err_fwd, bb: blk_back, bf: blk_fwd,
                  fb: frm_back, ff: frm_fwd, th: thresh, rd: rd_block};
            n_run++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model = '{eb: 4'd2, ef: 4'd2, bb: 5'd2, bf: 5'd8, fb: 5'd2, ff: 5'd8, th: 4'd15, rd: 8'd0};
        tick(3);
        rst_n = 1'b1;
        expect_now("R1 reset defaults");

        ser_xfer(8'hFA, 17'h00035, 16);
        model.eb = 4'd3; model.ef = 4'd5;
        expect_now("R2 R8 serial write reg0");

        ser_xfer(8'hFA, 17'h0F146, 16);
        model.bb = 5'd5; model.bf = 5'd7;
        expect_now("R3 upper bits ignored, reg1");

        ser_xfer(8'hFB, 17'h00099, 16);
        expect_now("R4 read code writes nothing");
        ser_xfer(8'h7A, 17'h00099, 16);
        expect_now("R4 wrong address code");

        ser_xfer(8'hFA, 17'h00077, 15);
        expect_now("R5 fifteen bits discarded");
        ser_xfer(8'hFA, 17'h000EE, 17);
        expect_now("R5 seventeen bits discarded");

        ser_xfer(8'hFA, 17'h00103, 16);
        model.bf = 5'd4;
        expect_now("R9 zero back nibble kept");

        ser_xfer(8'hFA, 17'h003F9, 16);
        model.th = 4'd9;
        expect_now("R10 threshold field 1");

        ser_xfer(8'hFA, 17'h004BE, 16);
        expect_now("R11 block 190 discarded");
        ser_xfer(8'hFA, 17'h004BD, 16);
        model.rd = 8'd189;
        expect_now("R11 block 189 stored");

        ser_xfer(8'hFA, 17'h00511, 16);
        expect_now("R12 serial reg5 ignored");

        ser_mode = 1'b0;
        tick(6);
        ser_xfer(8'hFA, 17'h00044, 16);
        expect_now("R7 serial ignored in parallel mode");

        par_xfer(3'd2, 8'h5A);
        model.fb = 5'd6; model.ff = 5'd11;
        expect_now("R6 R9 parallel reg2");

        par_xfer(3'd4, 8'd100);
        model.rd = 8'd100;
        expect_now("R6 parallel reg4");

        par_xfer(3'd7, 8'h11);
        expect_now("R12 parallel reg7 ignored");

        par_xfer(3'd1, 8'h00);
        expect_now("R9 zero nibbles unchanged");

        par_xfer(3'd3, 8'h02);
        model.th = 4'd10;
        expect_now("R10 threshold field 2");

        par_xfer(3'd0, 8'hA1);
        model.eb = 4'd10; model.ef = 4'd1;
        expect_now("R8 parallel reg0");

        ser_mode = 1'b1;
        tick(6);
        par_xfer(3'd0, 8'h33);
        expect_now("R7 parallel ignored in serial mode");

        tick(4);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule